// File: doc/BRIEF.md
# Microcontroller I/O Port Controller

This block sits between the instruction decoder of a small 4-bit microcontroller and the pad ring. It holds the output latches and direction state for eight 4-bit ports, numbered 0 to 7. Each cycle the CPU may raise at most one operation strobe, together with a port number, a 4-bit data word and a 4-bit bit mask. The operations are read, write, set bits, clear bits, test-all-ones, test-all-zeros and a direction write for the per-pin bidirectional port. The block returns read data and a one-cycle skip pulse. Toward the pads it drives per-pin output values, output enables, input enables, a group pull-down enable and the open-drain pull-down controls.

The port kinds are as follows. Ports 0 and 6 are input-only, and port 0 has a strap-selected group pull-down. Ports 1, 2 and 3 are push-pull outputs. Port 4 is bidirectional, and the last kind of access sets its direction for all four pins. Port 5 is bidirectional with a direction chosen per pin. Port 7 is an open-drain output. Reset and a backup (low-power) flag force the pads into defined safe states.

Read results leave on `rdata` with a one-cycle `rvalid` pulse. There is no ready signal. The CPU must accept `rdata` in the cycle `rvalid` is high, so the block never applies back-pressure and never stalls a strobe. `rdata` holds its value until the next read.

Top module: `iop_ctrl`

## Requirements
- R1: A read, test-all-ones or test-all-zeros on port 4 makes all four port 4 pins inputs (`pe_oe` = 0000) from the cycle after the strobe.
- R2: A write, set-bits or clear-bits on port 4 makes all four port 4 pins outputs (`pe_oe` = 1111, unless backup is high) from the cycle after the strobe.
- R3: `dir_stb` loads `wdata` into the port 5 direction register, where bit value 1 means output and 0 means input. `pf_oe` follows it from the next cycle. A read of port 5 returns the latch bit for output pins and the gated pad bit for input pins.
- R4: While `rst_n` is low, `pe_oe` and `pf_oe` are 0000, ports 1 to 3 drive 0 with their enables at 1111, `ph_pull` is 0000, and `skip` and `rvalid` are 0.
- R5: While `backup` is high, every output enable and `ph_pull` is 0000, every input enable is 0000, and a read of ports 0, 4 or 6 returns 0. Backup takes priority over reset at the pads.
- R6: `pa_pd` is 1111 when `cfg_pd` is 1 and 0000 when it is 0. The four pins always share one value.
- R7: A test-all-ones produces `skip` = 1 in the cycle after the strobe exactly when every masked bit of the port value is 1. A test-all-zeros does so exactly when every masked bit is 0. A zero mask therefore always skips. `skip` is 0 in every other cycle.
- R8: A write replaces the latch of ports 1, 2, 3, 4, 5 or 7. Set-bits ORs in `mask`, and clear-bits clears the `mask` bits, with the other bits unchanged. None of these has any effect on ports 0, 6 or 8 to 15.
- R9: A read raises `rvalid` for one cycle in the cycle after the strobe, with `rdata` holding the port value. Ports 1, 2, 3 and 7 return their latch, ports 0, 4 and 6 return their pads, and port numbers 8 to 15 return 0.
- R10: All output latches clear to 0 on reset. Latch updates made while backup is high appear on the pads when backup falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| backup | input | 1 | Low-power backup mode flag |
| cfg_pd | input | 1 | Strap option: port 0 group pull-down |
| port_sel | input | 4 | Port number of the current operation |
| wdata | input | 4 | Write data or port 5 direction mask |
| mask | input | 4 | Bit mask for set, clear and test |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| set_stb | input | 1 | Set-bits strobe |
| clr_stb | input | 1 | Clear-bits strobe |
| tt_stb | input | 1 | Test-all-ones strobe |
| tf_stb | input | 1 | Test-all-zeros strobe |
| dir_stb | input | 1 | Port 5 direction write strobe |
| rdata | output | 4 | Read result |
| rvalid | output | 1 | Read result valid pulse |
| skip | output | 1 | Skip pulse for test operations |
| pa_in | input | 4 | Port 0 pads |
| pa_ie | output | 4 | Port 0 input enables |
| pa_pd | output | 4 | Port 0 pull-down enables |
| pg_in | input | 4 | Port 6 pads |
| pg_ie | output | 4 | Port 6 input enables |
| pb_out | output | 4 | Port 1 output values |
| pb_oe | output | 4 | Port 1 output enables |
| pc_out | output | 4 | Port 2 output values |
| pc_oe | output | 4 | Port 2 output enables |
| pd_out | output | 4 | Port 3 output values |
| pd_oe | output | 4 | Port 3 output enables |
| pe_in | input | 4 | Port 4 pads |
| pe_out | output | 4 | Port 4 output values |
| pe_oe | output | 4 | Port 4 output enables |
| pe_ie | output | 4 | Port 4 input enables |
| pf_in | input | 4 | Port 5 pads |
| pf_out | output | 4 | Port 5 output values |
| pf_oe | output | 4 | Port 5 output enables |
| pf_ie | output | 4 | Port 5 input enables |
| ph_pull | output | 4 | Port 7 open-drain pull-low controls |

## Verification
Two functions can fall in the same cycle here. An operation on port 4 can flip its direction in the same cycle that it samples or writes the pins. A latch write can also arrive in the same cycle that backup gates every pad. The bench issues tests and writes on port 4 back to back with alternating kinds, and judges each by both the skip result and the following `pe_oe`. It also writes port 1 while backup is held high and confirms that the pads stay released until backup drops, then show the new value.

// File: rtl/iop_pkg.sv
package iop_pkg;
  localparam int NPORT = 8;
  localparam int SEL_W = 4;

  localparam logic [2:0] PID_A = 3'd0;
  localparam logic [2:0] PID_B = 3'd1;
  localparam logic [2:0] PID_C = 3'd2;
  localparam logic [2:0] PID_D = 3'd3;
  localparam logic [2:0] PID_E = 3'd4;
  localparam logic [2:0] PID_F = 3'd5;
  localparam logic [2:0] PID_G = 3'd6;
  localparam logic [2:0] PID_H = 3'd7;

  // ports that own an output latch
  function automatic bit has_latch(int p);
    return (p == 1) || (p == 2) || (p == 3) || (p == 4) || (p == 5) || (p == 7);
  endfunction
endpackage

// File: rtl/iop_latch.sv
module iop_latch #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit,
  input  logic         wr,
  input  logic         set,
  input  logic         clr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] mask,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q <= '0;
    else if (hit && wr)  q <= wdata;
    else if (hit && set) q <= q | mask;
    else if (hit && clr) q <= q & ~mask;
  end
endmodule

// File: rtl/iop_dir.sv
module iop_dir #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit_e,
  input  logic         in_kind,
  input  logic         out_kind,
  input  logic         dir_stb,
  input  logic [W-1:0] wdata,
  output logic         e_out,
  output logic [W-1:0] f_dir
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 e_out <= 1'b0;
    else if (hit_e && in_kind)  e_out <= 1'b0;
    else if (hit_e && out_kind) e_out <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       f_dir <= '0;
    else if (dir_stb) f_dir <= wdata;
  end
endmodule

// File: rtl/iop_sense.sv
module iop_sense
  import iop_pkg::*;
#(
  parameter int W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [SEL_W-1:0]          port_sel,
  input  logic                      rd,
  input  logic                      tt,
  input  logic                      tf,
  input  logic [W-1:0]              mask,
  input  logic [NPORT-1:0][W-1:0]   lat,
  input  logic [W-1:0]              f_dir,
  input  logic [W-1:0]              pa_v,
  input  logic [W-1:0]              pg_v,
  input  logic [W-1:0]              pe_v,
  input  logic [W-1:0]              pf_v,
  output logic [W-1:0]              rdata,
  output logic                      rvalid,
  output logic                      skip
);
  logic [W-1:0] samp;
  logic [W-1:0] sel_bits;

  always_comb begin
    samp = '0;
    if (!port_sel[SEL_W-1]) begin
      case (port_sel[2:0])
        PID_A:   samp = pa_v;
        PID_E:   samp = pe_v;
        PID_F:   samp = (lat[PID_F] & f_dir) | (pf_v & ~f_dir);
        PID_G:   samp = pg_v;
        default: samp = lat[port_sel[2:0]];
      endcase
    end
  end

  assign sel_bits = samp & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
      skip   <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= samp;
      skip <= (tt && (sel_bits == mask)) || (tf && (sel_bits == '0));
    end
  end
endmodule

// File: rtl/iop_ctrl.sv
module iop_ctrl
  import iop_pkg::*;
#(
  parameter int W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             backup,
  input  logic             cfg_pd,
  input  logic [SEL_W-1:0] port_sel,
  input  logic [W-1:0]     wdata,
  input  logic [W-1:0]     mask,
  input  logic             rd_stb,
  input  logic             wr_stb,
  input  logic             set_stb,
  input  logic             clr_stb,
  input  logic             tt_stb,
  input  logic             tf_stb,
  input  logic             dir_stb,
  output logic [W-1:0]     rdata,
  output logic             rvalid,
  output logic             skip,
  input  logic [W-1:0]     pa_in,
  output logic [W-1:0]     pa_ie,
  output logic [W-1:0]     pa_pd,
  input  logic [W-1:0]     pg_in,
  output logic [W-1:0]     pg_ie,
  output logic [W-1:0]     pb_out,
  output logic [W-1:0]     pb_oe,
  output logic [W-1:0]     pc_out,
  output logic [W-1:0]     pc_oe,
  output logic [W-1:0]     pd_out,
  output logic [W-1:0]     pd_oe,
  input  logic [W-1:0]     pe_in,
  output logic [W-1:0]     pe_out,
  output logic [W-1:0]     pe_oe,
  output logic [W-1:0]     pe_ie,
  input  logic [W-1:0]     pf_in,
  output logic [W-1:0]     pf_out,
  output logic [W-1:0]     pf_oe,
  output logic [W-1:0]     pf_ie,
  output logic [W-1:0]     ph_pull
);
  logic [NPORT-1:0][W-1:0] lat;
  logic [W-1:0]            f_dir;
  logic                    e_out;
  logic [W-1:0]            awake;
  logic                    in_kind;
  logic                    out_kind;

  assign awake    = {W{~backup}};
  assign in_kind  = rd_stb | tt_stb | tf_stb;
  assign out_kind = wr_stb | set_stb | clr_stb;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    if (has_latch(p)) begin : g_lat
      iop_latch #(.W(W)) u_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (port_sel == SEL_W'(p)),
        .wr    (wr_stb),
        .set   (set_stb),
        .clr   (clr_stb),
        .wdata (wdata),
        .mask  (mask),
        .q     (lat[p])
      );
    end else begin : g_nolat
      assign lat[p] = '0;
    end
  end

  iop_dir #(.W(W)) u_dir (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_e    (port_sel == {1'b0, PID_E}),
    .in_kind  (in_kind),
    .out_kind (out_kind),
    .dir_stb  (dir_stb),
    .wdata    (wdata),
    .e_out    (e_out),
    .f_dir    (f_dir)
  );

  iop_sense #(.W(W)) u_sense (
    .clk      (clk),
    .rst_n    (rst_n),
    .port_sel (port_sel),
    .rd       (rd_stb),
    .tt       (tt_stb),
    .tf       (tf_stb),
    .mask     (mask),
    .lat      (lat),
    .f_dir    (f_dir),
    .pa_v     (pa_in & awake),
    .pg_v     (pg_in & awake),
    .pe_v     (pe_in & awake),
    .pf_v     (pf_in & awake),
    .rdata    (rdata),
    .rvalid   (rvalid),
    .skip     (skip)
  );

  // pad side: backup releases every driver, reset leaves latches at zero
  assign pa_ie   = awake;
  assign pg_ie   = awake;
  assign pe_ie   = awake;
  assign pf_ie   = awake;
  assign pa_pd   = {W{cfg_pd}};
  assign pb_out  = lat[PID_B];
  assign pc_out  = lat[PID_C];
  assign pd_out  = lat[PID_D];
  assign pb_oe   = awake;
  assign pc_oe   = awake;
  assign pd_oe   = awake;
  assign pe_out  = lat[PID_E];
  assign pe_oe   = {W{e_out}} & awake;
  assign pf_out  = lat[PID_F];
  assign pf_oe   = f_dir & awake;
  assign ph_pull = lat[PID_H] & awake;
endmodule

// File: rtl/iop_ctrl_chk.sv
module iop_ctrl_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         backup,
  input logic         cfg_pd,
  input logic [3:0]   port_sel,
  input logic [W-1:0] mask,
  input logic         rd_stb,
  input logic         wr_stb,
  input logic         set_stb,
  input logic         clr_stb,
  input logic         tt_stb,
  input logic         tf_stb,
  input logic         rvalid,
  input logic         skip,
  input logic [W-1:0] pa_ie,
  input logic [W-1:0] pa_pd,
  input logic [W-1:0] pb_out,
  input logic [W-1:0] pb_oe,
  input logic [W-1:0] pe_oe,
  input logic [W-1:0] pf_oe,
  input logic [W-1:0] ph_pull
);
  logic hit_e;
  logic hit_b;
  assign hit_e = (port_sel == 4'd4);
  assign hit_b = (port_sel == 4'd1);

  a_r1_e_goes_input: assert property (@(posedge clk) disable iff (!rst_n)
    hit_e && (rd_stb || tt_stb || tf_stb) |=> pe_oe == '0);

  a_r2_e_goes_output: assert property (@(posedge clk) disable iff (!rst_n)
    hit_e && (wr_stb || set_stb || clr_stb) |=> backup || pe_oe == {W{1'b1}});

  a_r5_backup_released: assert property (@(posedge clk) disable iff (!rst_n)
    backup |-> (pb_oe == '0 && pe_oe == '0 && pf_oe == '0 && ph_pull == '0 && pa_ie == '0));

  a_r6_pd_group: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_pd == '0 && !cfg_pd) || (pa_pd == {W{1'b1}} && cfg_pd));

  a_r7_skip_after_test: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> $past(tt_stb || tf_stb));

  a_r9_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(rd_stb));

  a_r8_set_masked_only: assert property (@(posedge clk) disable iff (!rst_n)
    hit_b && set_stb |=> ((pb_out & $past(mask)) == $past(mask))
                      && ((pb_out & ~$past(mask)) == ($past(pb_out) & ~$past(mask))));

  a_r8_clr_masked_only: assert property (@(posedge clk) disable iff (!rst_n)
    hit_b && clr_stb |=> ((pb_out & $past(mask)) == '0)
                      && ((pb_out & ~$past(mask)) == ($past(pb_out) & ~$past(mask))));
endmodule

bind iop_ctrl iop_ctrl_chk #(.W(W)) i_chk (
  .clk(clk), .rst_n(rst_n), .backup(backup), .cfg_pd(cfg_pd),
  .port_sel(port_sel), .mask(mask),
  .rd_stb(rd_stb), .wr_stb(wr_stb), .set_stb(set_stb), .clr_stb(clr_stb),
  .tt_stb(tt_stb), .tf_stb(tf_stb), .rvalid(rvalid), .skip(skip),
  .pa_ie(pa_ie), .pa_pd(pa_pd), .pb_out(pb_out), .pb_oe(pb_oe),
  .pe_oe(pe_oe), .pf_oe(pf_oe), .ph_pull(ph_pull)
);

// File: tb/test_iop_ctrl.sv
module test_iop_ctrl;
  localparam int K_RD = 0, K_WR = 1, K_SET = 2, K_CLR = 3, K_TT = 4, K_TF = 5, K_DIR = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic backup = 1'b0, cfg_pd = 1'b0;
  logic [3:0] port_sel = '0, wdata = '0, mask = '0;
  logic rd_stb = 0, wr_stb = 0, set_stb = 0, clr_stb = 0, tt_stb = 0, tf_stb = 0, dir_stb = 0;
  logic [3:0] rdata;
  logic rvalid, skip;
  logic [3:0] pa_in = '0, pg_in = '0, pe_in = '0, pf_in = '0;
  logic [3:0] pa_ie, pa_pd, pg_ie, pb_out, pb_oe, pc_out, pc_oe, pd_out, pd_oe;
  logic [3:0] pe_out, pe_oe, pe_ie, pf_out, pf_oe, pf_ie, ph_pull;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [3:0] m_lat [8];
  logic       m_eout;
  logic [3:0] m_fdir;

  always #4 clk = ~clk;

  iop_ctrl i_iop_ctrl (.*);

  task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic bit latched(int p);
    return p == 1 || p == 2 || p == 3 || p == 4 || p == 5 || p == 7;
  endfunction

  function automatic logic [3:0] exp_val(int p);
    logic [3:0] aw;
    aw = backup ? 4'h0 : 4'hF;
    case (p)
      0: return pa_in & aw;
      4: return pe_in & aw;
      5: return (m_lat[5] & m_fdir) | (pf_in & aw & ~m_fdir);
      6: return pg_in & aw;
      1, 2, 3, 7: return m_lat[p];
      default: return 4'h0;
    endcase
  endfunction

  task automatic op(input int k, input int p, input logic [3:0] d, input logic [3:0] m);
    @(negedge clk);
    port_sel = p[3:0]; wdata = d; mask = m;
    rd_stb = (k == K_RD); wr_stb = (k == K_WR); set_stb = (k == K_SET);
    clr_stb = (k == K_CLR); tt_stb = (k == K_TT); tf_stb = (k == K_TF); dir_stb = (k == K_DIR);
    @(negedge clk);
    rd_stb = 0; wr_stb = 0; set_stb = 0; clr_stb = 0; tt_stb = 0; tf_stb = 0; dir_stb = 0;
    if (latched(p)) begin
      if (k == K_WR) m_lat[p] = d;
      if (k == K_SET) m_lat[p] = m_lat[p] | m;
      if (k == K_CLR) m_lat[p] = m_lat[p] & ~m;
    end
    if (p == 4 && (k == K_RD || k == K_TT || k == K_TF)) m_eout = 0;
    if (p == 4 && (k == K_WR || k == K_SET || k == K_CLR)) m_eout = 1;
    if (k == K_DIR) m_fdir = d;
  endtask

  task automatic do_read(input string req, input int p);
    logic [3:0] e;
    e = exp_val(p);
    op(K_RD, p, 4'h0, 4'h0);
    chk(req, {3'b0, rvalid}, 4'h1);
    chk(req, rdata, e);
  endtask

  task automatic do_test(input string req, input bit tt, input int p, input logic [3:0] m);
    logic [3:0] v;
    bit e;
    v = exp_val(p) & m;
    e = tt ? (v == m) : (v == 4'h0);
    op(tt ? K_TT : K_TF, p, 4'h0, m);
    chk(req, {3'b0, skip}, {3'b0, e});
    @(negedge clk);
    chk(req, {3'b0, skip}, 4'h0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_lat[i] = 4'h0;
    m_eout = 0; m_fdir = 4'h0;
    repeat (3) @(negedge clk);
    // R4 reset state
    chk("R4 pb_oe", pb_oe, 4'hF); chk("R4 pb_out", pb_out, 4'h0);
    chk("R4 pc_out", pc_out, 4'h0); chk("R4 pd_oe", pd_oe, 4'hF);
    chk("R4 pe_oe", pe_oe, 4'h0); chk("R4 pf_oe", pf_oe, 4'h0);
    chk("R4 ph_pull", ph_pull, 4'h0); chk("R4 skip", {3'b0, skip}, 4'h0);
    chk("R4 rvalid", {3'b0, rvalid}, 4'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 pull-down group
    for (int c = 0; c < 2; c++) begin
      cfg_pd = c[0]; #1;
      chk("R6 pa_pd", pa_pd, c[0] ? 4'hF : 4'h0);
    end

    // R8 R9 write then read every port number
    for (int p = 0; p < 16; p++)
      for (int d = 0; d < 16; d += 5) begin
        pa_in = 4'(d ^ 4'h9); pg_in = 4'(d ^ 4'h6); pe_in = 4'(d ^ 4'h3); pf_in = 4'(~d);
        op(K_WR, p, 4'(d), 4'h0);
        do_read("R9 read after write", p);
      end
    chk("R8 port1 pad", pb_out, m_lat[1]);
    chk("R8 port7 pull", ph_pull, m_lat[7]);

    // R8 set and clear, exhaustive start value x mask on port 1
    for (int s = 0; s < 16; s++)
      for (int m = 0; m < 16; m++) begin
        op(K_WR, 1, 4'(s), 4'h0);
        op(K_SET, 1, 4'h0, 4'(m));
        chk("R8 set", pb_out, 4'(s | m));
        op(K_CLR, 1, 4'h0, 4'(m));
        chk("R8 clr", pb_out, 4'(s & ~m));
      end
    // R8 set/clr on input-only and unused ports leave other latches alone
    op(K_WR, 2, 4'h5, 4'h0);
    op(K_SET, 0, 4'h0, 4'hF); op(K_SET, 6, 4'h0, 4'hF); op(K_CLR, 10, 4'h0, 4'hF);
    chk("R8 ignored ops", pc_out, 4'h5);
    pa_in = 4'h0; do_read("R8 port0 no latch", 0);

    // R7 exhaustive tests on port 0 pads
    for (int v = 0; v < 16; v++)
      for (int m = 0; m < 16; m++) begin
        pa_in = 4'(v);
        do_test("R7 test-ones", 1, 0, 4'(m));
        do_test("R7 test-zeros", 0, 0, 4'(m));
      end

    // R1 R2 port 4 direction, alternating kinds back to back
    pe_in = 4'hA;
    op(K_WR, 4, 4'h3, 4'h0);  chk("R2 write", pe_oe, 4'hF); chk("R2 pe_out", pe_out, 4'h3);
    do_test("R1 test-ones on 4", 1, 4, 4'hA); chk("R1 after tt", pe_oe, 4'h0);
    op(K_SET, 4, 4'h0, 4'h4); chk("R2 set", pe_oe, 4'hF); chk("R2 set val", pe_out, 4'h7);
    do_test("R1 test-zeros on 4", 0, 4, 4'h5); chk("R1 after tf", pe_oe, 4'h0);
    op(K_CLR, 4, 4'h0, 4'h1); chk("R2 clr", pe_oe, 4'hF); chk("R2 clr val", pe_out, 4'h6);
    do_read("R1 read on 4", 4); chk("R1 after rd", pe_oe, 4'h0);

    // R3 port 5 per-pin direction
    op(K_WR, 5, 4'hA, 4'h0);
    pf_in = 4'h5;
    for (int d = 0; d < 16; d++) begin
      op(K_DIR, 5, 4'(d), 4'h0);
      chk("R3 pf_oe", pf_oe, 4'(d));
      chk("R3 pf_out", pf_out, 4'hA);
      do_read("R3 mixed read", 5);
    end

    // R5 R10 backup
    op(K_WR, 1, 4'h3, 4'h0);
    op(K_WR, 4, 4'h9, 4'h0);
    op(K_WR, 7, 4'hF, 4'h0);
    op(K_DIR, 5, 4'hF, 4'h0);
    @(negedge clk); backup = 1'b1;
    pa_in = 4'hF; pg_in = 4'hF; pe_in = 4'hF;
    op(K_WR, 1, 4'hC, 4'h0);
    chk("R5 pb_oe", pb_oe, 4'h0); chk("R5 pc_oe", pc_oe, 4'h0);
    chk("R5 pe_oe", pe_oe, 4'h0); chk("R5 pf_oe", pf_oe, 4'h0);
    chk("R5 ph_pull", ph_pull, 4'h0); chk("R5 pa_ie", pa_ie, 4'h0);
    chk("R5 pg_ie", pg_ie, 4'h0); chk("R5 pe_ie", pe_ie, 4'h0); chk("R5 pf_ie", pf_ie, 4'h0);
    do_read("R5 port0 disabled", 0);
    do_read("R5 port6 disabled", 6);
    op(K_WR, 4, 4'h9, 4'h0);
    do_read("R5 port4 disabled", 4);
    @(negedge clk); backup = 1'b0; #1;
    chk("R10 latch kept across backup", pb_out, 4'hC);
    chk("R10 pb_oe back", pb_oe, 4'hF);
    chk("R10 ph_pull back", ph_pull, 4'hF);

    // R10 reset clears latches; R4 again mid-run
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R10 pb_out reset", pb_out, 4'h0); chk("R4 pe_oe reset", pe_oe, 4'h0);
    chk("R4 pf_oe reset", pf_oe, 4'h0); chk("R10 ph_pull reset", ph_pull, 4'h0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 8; i++) m_lat[i] = 4'h0;
    m_eout = 0; m_fdir = 4'h0;
    do_read("R10 port7 after reset", 7);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule